// File: doc/BRIEF.md
# Timer Compare Register Access Router

This block decides, in the same cycle, where a system-register access to a physical-timer compare value goes. The access arrives through one of two encodings. The hypervisor alias always names the level-2 timer. The user alias names whichever compare register fits the current privilege level, host-mode setting and security state. The access is also checked against a set of timer access enables and nested-virtualization controls.

Exactly one outcome results from each access: the access is undefined, it traps to level 1 or level 2 with a fixed syndrome class, it is redirected to a fixed slot in a memory-backed register page, or it reaches one of three compare registers (guest, hypervisor, secure hypervisor). Reads and writes resolve identically. The direction only chooses which strobe, read or write, accompanies a memory or register target. The block is purely combinational. Register storage and exception entry sit in neighbouring blocks.

In the requirements, "level 2 in host mode" means `el2_en_i & host_i`, and "level 0 in host mode" means that term ANDed with `tge_i`.

Top module: `tmr_cval_router`

## Requirements
- R1: A hypervisor-alias access (`hyp_alias_i`=1) at level 0 is undefined. At level 2 or 3 it targets the hypervisor register (`tgt_sel_o`=1).
- R2: A hypervisor-alias access at level 1 traps to level 2 when `nv_i[0]`=1, and is undefined otherwise.
- R3: A user-alias access (`hyp_alias_i`=0) at level 0 that is not in host mode, with `usr_el0_en_i`=0, traps. The trap goes to level 2 when `el2_en_i` and `tge_i` are both 1, and to level 1 otherwise.
- R4: A user-alias access at level 0 or 1 traps to level 2 in two cases. The first is level 2 enabled, not in host mode, with `el1_cnt_en_i`=0. The second is level 2 in host mode with `el1_tmr_en_i`=0, which at level 0 applies only when `tge_i`=0.
- R5: A user-alias access at level 0 in host mode with `host_el0_en_i`=0 traps to level 2.
- R6: A user-alias access at level 1 with `nv_i`=3'b111 and no trap from R4 is redirected to memory, with `mem_off_o`=0x178.
- R7: A user-alias access at level 2 with level 2 in host mode, or at level 0 in host mode, is steered by security state. It targets the secure hypervisor register (`tgt_sel_o`=2) when `secure_i`=1 and `sec_el2_i`=1. It targets the hypervisor register (1) when `secure_i`=0. Otherwise it targets the guest register (0).
- R8: A user-alias access at level 3, or one matching no other rule, targets the guest register (`tgt_sel_o`=0).
- R9: Every trap drives `trap_ec_o`=0x18 with `trap_el_o` set to 1 or 2. Exactly one of `undef_o`, `trap_o`, `mem_o` and `tgt_o` is high for every access.
- R10: `rd_en_o`/`wr_en_o` are high only with `mem_o` or `tgt_o`, chosen by `wr_i` (1 = write). Routing does not depend on `wr_i`.
- R11: Conditions are checked in a fixed priority: a trap condition at level 1 overrides the memory redirect, and the R3 trap overrides the later level-0 conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| el_i | input | 2 | Current privilege level 0..3 |
| wr_i | input | 1 | 1 = write, 0 = read |
| hyp_alias_i | input | 1 | 1 = hypervisor alias encoding, 0 = user alias |
| el2_en_i | input | 1 | Level 2 enabled in the current state |
| host_i | input | 1 | Host-mode control |
| tge_i | input | 1 | Trap-general control |
| nv_i | input | 3 | Nested-virtualization controls |
| usr_el0_en_i | input | 1 | Level-1 owned level-0 timer access enable |
| el1_cnt_en_i | input | 1 | Level-2 owned level-1 counter access enable |
| el1_tmr_en_i | input | 1 | Level-2 owned level-1 timer access enable (host mode) |
| host_el0_en_i | input | 1 | Level-2 owned level-0 timer access enable (host mode) |
| secure_i | input | 1 | Current security state is secure |
| sec_el2_i | input | 1 | Secure level 2 supported |
| undef_o | output | 1 | Access is undefined |
| trap_o | output | 1 | Access traps |
| trap_el_o | output | 2 | Trap target level (0 when no trap) |
| trap_ec_o | output | 6 | Trap syndrome class (0x18 when trapping) |
| mem_o | output | 1 | Access redirected to memory |
| mem_off_o | output | 12 | Memory slot offset |
| tgt_o | output | 1 | Access reaches a compare register |
| tgt_sel_o | output | 2 | 0 guest, 1 hypervisor, 2 secure hypervisor |
| rd_en_o | output | 1 | Read strobe to the chosen target |
| wr_en_o | output | 1 | Write strobe to the chosen target |

## Verification
Each privilege level is run with both aliases. At each level, the controls are toggled one at a time from an all-permissive baseline, so each trap condition is shown to fire on its own control bit alone. Combinations that make two rules true at once, such as all nested-virtualization bits set with a cleared counter enable, or a cleared level-0 enable in and out of host mode, separate the priority order from a flat OR of conditions. The three security/support combinations under host mode distinguish the secure hypervisor, hypervisor and guest targets. Repeating accesses as reads and writes shows that the direction changes only the strobes.

// File: rtl/tmr_cval_pkg.sv
package tmr_cval_pkg;

  typedef enum logic [1:0] {
    TGT_GUEST = 2'd0,
    TGT_HYP   = 2'd1,
    TGT_SHYP  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic       undef;
    logic       trap;
    logic [1:0] trap_el;
    logic       mem;
    logic       tgt;
    tgt_e       tgt_sel;
  } route_t;

  localparam logic [1:0] LVL0 = 2'd0;
  localparam logic [1:0] LVL1 = 2'd1;
  localparam logic [1:0] LVL2 = 2'd2;
  localparam logic [1:0] LVL3 = 2'd3;

  function automatic route_t mk_undef();
    route_t r = '0;
    r.undef = 1'b1;
    return r;
  endfunction

  function automatic route_t mk_trap(input logic [1:0] lvl);
    route_t r = '0;
    r.trap    = 1'b1;
    r.trap_el = lvl;
    return r;
  endfunction

  function automatic route_t mk_mem();
    route_t r = '0;
    r.mem = 1'b1;
    return r;
  endfunction

  function automatic route_t mk_tgt(input tgt_e sel);
    route_t r = '0;
    r.tgt     = 1'b1;
    r.tgt_sel = sel;
    return r;
  endfunction

endpackage

// File: rtl/tmr_cval_hyp_dec.sv
module tmr_cval_hyp_dec
  import tmr_cval_pkg::*;
(
  input  logic [1:0] el_i,
  input  logic       nv0_i,
  output route_t     route_o
);

  always_comb begin
    unique case (el_i)
      LVL0:    route_o = mk_undef();
      LVL1:    route_o = nv0_i ? mk_trap(LVL2) : mk_undef();
      default: route_o = mk_tgt(TGT_HYP);
    endcase
  end

  always_comb begin
    if (!$isunknown({el_i, nv0_i})) begin
      AST_HYP_EL0_UNDEF: assert (el_i != LVL0 || route_o.undef) else $error("hyp alias el0"); // R1
      AST_HYP_EL1_NOTGT: assert (el_i != LVL1 || !route_o.tgt) else $error("hyp alias el1 tgt"); // R2
    end
  end

endmodule

// File: rtl/tmr_cval_usr_dec.sv
module tmr_cval_usr_dec
  import tmr_cval_pkg::*;
(
  input  logic [1:0] el_i,
  input  logic       el2_en_i,
  input  logic       host_i,
  input  logic       tge_i,
  input  logic [2:0] nv_i,
  input  logic       usr_el0_en_i,
  input  logic       el1_cnt_en_i,
  input  logic       el1_tmr_en_i,
  input  logic       host_el0_en_i,
  input  logic       secure_i,
  input  logic       sec_el2_i,
  output route_t     route_o
);

  logic   host2, host0;
  route_t sec_pick;

  assign host2 = el2_en_i & host_i;
  assign host0 = host2 & tge_i;

  // host-mode register choice shared by level 0 and level 2
  always_comb begin
    if (secure_i && sec_el2_i) sec_pick = mk_tgt(TGT_SHYP);
    else if (!secure_i)        sec_pick = mk_tgt(TGT_HYP);
    else                       sec_pick = mk_tgt(TGT_GUEST);
  end

  always_comb begin
    route_o = mk_tgt(TGT_GUEST);
    unique case (el_i)
      LVL0: begin
        if (!host0 && !usr_el0_en_i)
          route_o = mk_trap((el2_en_i && tge_i) ? LVL2 : LVL1);
        else if (el2_en_i && !host2 && !el1_cnt_en_i)
          route_o = mk_trap(LVL2);
        else if (host2 && !tge_i && !el1_tmr_en_i)
          route_o = mk_trap(LVL2);
        else if (host0 && !host_el0_en_i)
          route_o = mk_trap(LVL2);
        else if (host0)
          route_o = sec_pick;
      end
      LVL1: begin
        if (el2_en_i && !host2 && !el1_cnt_en_i)
          route_o = mk_trap(LVL2);
        else if (host2 && !el1_tmr_en_i)
          route_o = mk_trap(LVL2);
        else if (&nv_i)
          route_o = mk_mem();
      end
      LVL2: begin
        if (host2) route_o = sec_pick;
      end
      default: route_o = mk_tgt(TGT_GUEST);
    endcase
  end

  always_comb begin
    if (!$isunknown({el_i, el2_en_i, host_i, tge_i, nv_i, usr_el0_en_i, el1_cnt_en_i,
                     el1_tmr_en_i, host_el0_en_i, secure_i, sec_el2_i})) begin
      AST_MEM_ONLY_EL1: assert (!route_o.mem || (el_i == LVL1 && &nv_i)) else $error("mem route"); // R6
      AST_USR_EL3_GUEST: assert (el_i != LVL3 || (route_o.tgt && route_o.tgt_sel == TGT_GUEST))
        else $error("el3 route"); // R8
      AST_EL1_PRIO: assert (!(el_i == LVL1 && el2_en_i && !host_i && !el1_cnt_en_i) || route_o.trap)
        else $error("el1 prio"); // R11
    end
  end

endmodule

// File: rtl/tmr_cval_router.sv
module tmr_cval_router
  import tmr_cval_pkg::*;
#(
  parameter int               EC_W    = 6,
  parameter logic [EC_W-1:0]  EC_VAL  = 6'h18,
  parameter int               OFF_W   = 12,
  parameter logic [OFF_W-1:0] MEM_OFF = 12'h178
) (
  input  logic             [1:0] el_i,
  input  logic                   wr_i,
  input  logic                   hyp_alias_i,
  input  logic                   el2_en_i,
  input  logic                   host_i,
  input  logic                   tge_i,
  input  logic             [2:0] nv_i,
  input  logic                   usr_el0_en_i,
  input  logic                   el1_cnt_en_i,
  input  logic                   el1_tmr_en_i,
  input  logic                   host_el0_en_i,
  input  logic                   secure_i,
  input  logic                   sec_el2_i,
  output logic                   undef_o,
  output logic                   trap_o,
  output logic             [1:0] trap_el_o,
  output logic        [EC_W-1:0] trap_ec_o,
  output logic                   mem_o,
  output logic       [OFF_W-1:0] mem_off_o,
  output logic                   tgt_o,
  output logic             [1:0] tgt_sel_o,
  output logic                   rd_en_o,
  output logic                   wr_en_o
);

  route_t r_hyp, r_usr, r_sel;
  logic   dat_ok;

  tmr_cval_hyp_dec u_hyp (
    .el_i   (el_i),
    .nv0_i  (nv_i[0]),
    .route_o(r_hyp)
  );

  tmr_cval_usr_dec u_usr (
    .el_i         (el_i),
    .el2_en_i     (el2_en_i),
    .host_i       (host_i),
    .tge_i        (tge_i),
    .nv_i         (nv_i),
    .usr_el0_en_i (usr_el0_en_i),
    .el1_cnt_en_i (el1_cnt_en_i),
    .el1_tmr_en_i (el1_tmr_en_i),
    .host_el0_en_i(host_el0_en_i),
    .secure_i     (secure_i),
    .sec_el2_i    (sec_el2_i),
    .route_o      (r_usr)
  );

  assign r_sel     = hyp_alias_i ? r_hyp : r_usr;
  assign dat_ok    = r_sel.mem | r_sel.tgt;

  assign undef_o   = r_sel.undef;
  assign trap_o    = r_sel.trap;
  assign trap_el_o = r_sel.trap ? r_sel.trap_el : 2'd0;
  assign trap_ec_o = r_sel.trap ? EC_VAL : '0;
  assign mem_o     = r_sel.mem;
  assign mem_off_o = r_sel.mem ? MEM_OFF : '0;
  assign tgt_o     = r_sel.tgt;
  assign tgt_sel_o = r_sel.tgt ? r_sel.tgt_sel : TGT_GUEST;
  assign rd_en_o   = dat_ok & ~wr_i;
  assign wr_en_o   = dat_ok & wr_i;

  always_comb begin
    if (!$isunknown({el_i, wr_i, hyp_alias_i, el2_en_i, host_i, tge_i, nv_i, usr_el0_en_i,
                     el1_cnt_en_i, el1_tmr_en_i, host_el0_en_i, secure_i, sec_el2_i})) begin
      AST_ONE_OUTCOME: assert ($countones({undef_o, trap_o, mem_o, tgt_o}) == 1)
        else $error("outcome count"); // R9
      AST_TRAP_LEVEL: assert (!trap_o || trap_el_o == 2'd1 || trap_el_o == 2'd2)
        else $error("trap level"); // R9
      AST_STROBE_DIR: assert ($onehot0({rd_en_o, wr_en_o}) && (!wr_en_o || wr_i) && (!rd_en_o || !wr_i))
        else $error("strobe dir"); // R10
      AST_NO_STROBE_FAULT: assert (!(undef_o || trap_o) || !(rd_en_o || wr_en_o))
        else $error("strobe on fault"); // R10
      AST_EL3_ALLOWED: assert (el_i != LVL3 || tgt_o) else $error("el3 fault"); // R1
    end
  end

endmodule

// File: tb/sim_tmr_cval_router.sv
module sim_tmr_cval_router;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] el = 2'd3;
  logic wr = 1'b0, hyp = 1'b0, el2_en = 1'b1, host = 1'b0, tge = 1'b0;
  logic [2:0] nv = 3'd0;
  logic k0 = 1'b1, pcen = 1'b1, pten = 1'b1, h0 = 1'b1, sec = 1'b0, sel2 = 1'b0;

  logic undef_o, trap_o, mem_o, tgt_o, rd_en_o, wr_en_o;
  logic [1:0] trap_el_o, tgt_sel_o;
  logic [5:0] trap_ec_o;
  logic [11:0] mem_off_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tmr_cval_router u0 (
    .el_i(el), .wr_i(wr), .hyp_alias_i(hyp), .el2_en_i(el2_en), .host_i(host), .tge_i(tge),
    .nv_i(nv), .usr_el0_en_i(k0), .el1_cnt_en_i(pcen), .el1_tmr_en_i(pten),
    .host_el0_en_i(h0), .secure_i(sec), .sec_el2_i(sel2),
    .undef_o(undef_o), .trap_o(trap_o), .trap_el_o(trap_el_o), .trap_ec_o(trap_ec_o),
    .mem_o(mem_o), .mem_off_o(mem_off_o), .tgt_o(tgt_o), .tgt_sel_o(tgt_sel_o),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o)
  );

  // {undef, trap, trap_el[1:0], mem, tgt, tgt_sel[1:0]}
  localparam logic [7:0] E_UNDEF = 8'b1000_0000;
  localparam logic [7:0] E_MEM   = 8'b0000_1000;
  function automatic logic [7:0] e_trap(input logic [1:0] l);
    return {2'b01, l, 4'b0000};
  endfunction
  function automatic logic [7:0] e_tgt(input logic [1:0] s);
    return {6'b000001, s};
  endfunction

  task automatic base();
    el = 2'd3; wr = 0; hyp = 0; el2_en = 1; host = 0; tge = 0; nv = 3'd0;
    k0 = 1; pcen = 1; pten = 1; h0 = 1; sec = 0; sel2 = 0;
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    logic [9:0] act, want;
    logic dok;
    @(negedge clk); #1;
    dok  = exp[3] | exp[2];
    want = {exp, dok & ~wr, dok & wr};
    act  = {undef_o, trap_o, trap_el_o, mem_o, tgt_o, tgt_sel_o, rd_en_o, wr_en_o};
    n_chk++;
    if (act !== want) begin
      n_bad++;
      $display("FAIL %s: route act=%b exp=%b", req, act, want);
    end
    if (exp[6]) begin
      n_chk++;
      if (trap_ec_o !== 6'h18) begin
        n_bad++;
        $display("FAIL R9: class act=%h exp=18", trap_ec_o);
      end
    end
    if (exp[3]) begin
      n_chk++;
      if (mem_off_o !== 12'h178) begin
        n_bad++;
        $display("FAIL R6: offset act=%h exp=178", mem_off_o);
      end
    end
  endtask

  task automatic t_idle();
    base();
    check("R8 idle", e_tgt(2'd0));
  endtask

  task automatic t_hyp_alias();
    base(); hyp = 1;
    el = 0; check("R1 el0", E_UNDEF);
    el = 2; check("R1 el2", e_tgt(2'd1));
    el = 3; check("R1 el3", e_tgt(2'd1));
    el = 1; nv = 3'b001; check("R2 nv0 set", e_trap(2'd2));
    nv = 3'b110; check("R2 nv0 clear", E_UNDEF);
  endtask

  task automatic t_usr_el0();
    base(); el = 0;
    k0 = 0; check("R3 tge0", e_trap(2'd1));
    tge = 1; check("R3 tge1", e_trap(2'd2));
    el2_en = 0; check("R3 el2 off", e_trap(2'd1));
    base(); el = 0; k0 = 0; pcen = 0; check("R11 r3 first", e_trap(2'd1));
    k0 = 1; check("R4 pcen", e_trap(2'd2));
    base(); el = 0; host = 1; pten = 0; check("R4 host pten", e_trap(2'd2));
    base(); el = 0; host = 1; tge = 1; pten = 0; k0 = 0; check("R7 host0 ignores k0/pten", e_tgt(2'd1));
    h0 = 0; check("R5 host el0 en", e_trap(2'd2));
    h0 = 1; sec = 1; sel2 = 1; check("R7 el0 secure", e_tgt(2'd2));
    sel2 = 0; check("R7 el0 secure nosupp", e_tgt(2'd0));
    base(); el = 0; check("R8 el0 plain", e_tgt(2'd0));
  endtask

  task automatic t_usr_el1();
    base(); el = 1; nv = 3'b111; check("R6 mem", E_MEM);
    pcen = 0; check("R11 pcen over mem", e_trap(2'd2));
    base(); el = 1; nv = 3'b111; host = 1; pten = 0; check("R11 pten over mem", e_trap(2'd2));
    base(); el = 1; nv = 3'b011; check("R8 partial nv", e_tgt(2'd0));
    base(); el = 1; el2_en = 0; pcen = 0; check("R4 el2 off", e_tgt(2'd0));
  endtask

  task automatic t_usr_el2();
    base(); el = 2; host = 1; check("R7 nonsecure", e_tgt(2'd1));
    sec = 1; sel2 = 1; check("R7 secure", e_tgt(2'd2));
    host = 0; check("R7 no host", e_tgt(2'd0));
  endtask

  task automatic t_usr_el3();
    base(); el = 3; host = 1; tge = 1; sec = 1; sel2 = 1; k0 = 0; pcen = 0; pten = 0; h0 = 0;
    check("R8 el3", e_tgt(2'd0));
  endtask

  task automatic t_dir();
    base(); el = 2; hyp = 1; wr = 1; check("R10 write", e_tgt(2'd1));
    wr = 0; check("R10 read", e_tgt(2'd1));
    base(); el = 1; nv = 3'b111; wr = 1; check("R10 mem write", E_MEM);
    base(); hyp = 1; el = 0; wr = 1; check("R10 undef write", E_UNDEF);
    base(); el = 0; k0 = 0; wr = 1; check("R10 trap write", e_trap(2'd1));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_hyp_alias();
    t_usr_el0();
    t_usr_el1();
    t_usr_el2();
    t_usr_el3();
    t_dir();
    finish_run();
  end

endmodule